// File: doc/BRIEF.md
# Wrapping Sync Counter Array

This block keeps a small bank of free-running 32-bit synchronization counters. Hardware engines pulse an increment strobe with a counter index whenever they finish a unit of work. A waiting party learns that the work is done by comparing a counter against a target value. The block offers two ways to wait. A consuming channel presents an index and a target, and the block holds it stalled until the target is reached. A per-counter threshold register drives a sticky, maskable interrupt line.

Every comparison works on the 32-bit circle. The half circle from the target onward counts as reached. The half circle just before the target counts as still pending. Because of this, counters never need to be reset while the system runs. A register port reads counters, thresholds, enables and status bits at any time. It also programs thresholds and enables, clears status bits, and applies software increments.

Top module: `sync_counter_array`

## Requirements
- R1: After a synchronous active-low reset, every counter, threshold, enable and status bit reads zero, and `irq` is all zero.
- R2: Each increment strobe adds exactly one to the addressed counter and wraps modulo 2^CNT_W, so the all-ones value becomes zero.
- R3: All strobes in one cycle are applied. Strobes on different indices each take effect, and strobes on the same index (from several engine ports and/or a software increment) add together.
- R4: A counter has reached a target when bit CNT_W-1 of (counter − target) mod 2^CNT_W is 0. For example, with target all-ones and counter 0 it is reached, and with target 0 and counter 2^(CNT_W-1) it is not.
- R5: `chan_stall` is high exactly when `chan_wait` is high and the counter at `chan_idx` has not reached `chan_thresh`. It is computed from the registered counter, so it drops in the cycle after the increment edge that reaches the target.
- R6: A status bit is set at the clock edge after its counter-versus-threshold condition changes from not reached to reached. Once set, it stays set until it is cleared.
- R7: Writing a value with bit 0 set to a status address clears that status bit, and writing bit 0 as 0 leaves it unchanged. A new set event in the same cycle wins over the clear.
- R8: `irq[i]` equals status bit i AND enable bit i.
- R9: `reg_addr` is {sel[1:0], idx}. The sel field selects the register:
  - sel 0 reads the counter; a write to it is a software increment by one, and the data is ignored.
  - sel 1 is the threshold, which can be read and written.
  - sel 2 is the enable, in bit 0.
  - sel 3 is the status, in bit 0.
  
  Reads are combinational, and unused upper bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| eng_inc_vld | input | N_ENG | Per-engine-port increment strobe |
| eng_inc_idx | input | N_ENG*IDXW | Packed counter index per engine port |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | IDXW+2 | {sel, idx} register address |
| reg_wdata | input | CNT_W | Register write data |
| reg_rdata | output | CNT_W | Combinational read data for reg_addr |
| chan_wait | input | 1 | Channel has a pending wait |
| chan_idx | input | IDXW | Counter the channel waits on |
| chan_thresh | input | CNT_W | Target value of the channel wait |
| chan_stall | output | 1 | Hold the channel |
| irq | output | N_CNT | Per-counter interrupt |

## Verification
A lost or doubled increment shows up in the counter read-back the cycle after the strobe. It also shifts the release of `chan_stall` by a cycle. A wrong sign choice in the circular compare only becomes visible near wraparound or far from the target. For that reason, a second instance with an 8-bit counter width runs the same stimulus through many wraps. A status register that misses an edge, or that is cleared wrongly, shows on `irq` one cycle after the edge that reaches the threshold.

// File: rtl/sca_pkg.sv
// Shared types for the sync counter array.
// Assumes the register address carries a two-bit select above the index.
package sca_pkg;
    typedef enum logic [1:0] {
        SEL_COUNT  = 2'd0,
        SEL_THRESH = 2'd1,
        SEL_ENABLE = 2'd2,
        SEL_STATUS = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/sca_inc_decode.sv
// Turns engine strobes and a software increment into one add amount per counter.
// Assumes every strobe adds one; strobes on the same index accumulate.
module sca_inc_decode #(
    parameter int N_CNT = 8,
    parameter int N_ENG = 2,
    parameter int IDXW  = 3,
    parameter int AMTW  = 2
) (
    input  logic [N_ENG-1:0]      eng_vld,
    input  logic [N_ENG*IDXW-1:0] eng_idx,
    input  logic                  sw_vld,
    input  logic [IDXW-1:0]       sw_idx,
    output logic [N_CNT*AMTW-1:0] amt
);
    for (genvar i = 0; i < N_CNT; i++) begin : g_cnt
        logic [AMTW-1:0] acc;
        // Count the hits that target counter i in this cycle.
        always_comb begin
            acc = '0;
            for (int p = 0; p < N_ENG; p++) begin
                if (eng_vld[p] && (eng_idx[p*IDXW +: IDXW] == IDXW'(i))) begin
                    acc = acc + AMTW'(1);
                end
            end
            if (sw_vld && (sw_idx == IDXW'(i))) begin
                acc = acc + AMTW'(1);
            end
        end
        assign amt[i*AMTW +: AMTW] = acc;
    end
endmodule

// File: rtl/sca_slot.sv
// One counter with its threshold, interrupt enable and sticky status bit.
// Assumes reset state counter == threshold == 0, which already counts as reached.
module sca_slot #(
    parameter int CW   = 32,
    parameter int AMTW = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AMTW-1:0] amt,
    input  logic            thr_we,
    input  logic [CW-1:0]   thr_wdata,
    input  logic            en_we,
    input  logic            en_wdata,
    input  logic            st_clr,
    output logic [CW-1:0]   cnt,
    output logic [CW-1:0]   thr,
    output logic            en,
    output logic            st,
    output logic            reached
);
    logic [CW-1:0] diff;
    logic          reached_q;

    // Circular compare: reached when the modular difference is non-negative.
    always_comb begin
        diff    = cnt - thr;
        reached = ~diff[CW-1];
    end

    // Counter advances by the number of hits this cycle, wrapping freely.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt + CW'(amt);
    end

    // Threshold and enable registers written from the register port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr <= '0;
            en  <= 1'b0;
        end else begin
            if (thr_we) thr <= thr_wdata;
            if (en_we)  en  <= en_wdata;
        end
    end

    // Sticky status: set on a not-reached to reached edge, set wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reached_q <= 1'b1;
            st        <= 1'b0;
        end else begin
            reached_q <= reached;
            st        <= (st & ~st_clr) | (reached & ~reached_q);
        end
    end

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> cnt == $past(cnt) + CW'($past(amt)));                   // R2
    AST_STATUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (reached && !reached_q) |=> st);                                 // R6
    AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st && !st_clr) |=> st);                                         // R7
endmodule

// File: rtl/sync_counter_array.sv
// Top: bank of wrapping sync counters with register port, channel stall and interrupts.
// Assumes N_CNT is a power of two so every index value names a counter.
module sync_counter_array #(
    parameter int N_CNT = 8,
    parameter int N_ENG = 2,
    parameter int CNT_W = 32,
    localparam int IDXW   = $clog2(N_CNT),
    localparam int AMTW   = $clog2(N_ENG + 2),
    localparam int ADDR_W = IDXW + 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N_ENG-1:0]      eng_inc_vld,
    input  logic [N_ENG*IDXW-1:0] eng_inc_idx,
    input  logic                  reg_wr,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic [CNT_W-1:0]      reg_wdata,
    output logic [CNT_W-1:0]      reg_rdata,
    input  logic                  chan_wait,
    input  logic [IDXW-1:0]       chan_idx,
    input  logic [CNT_W-1:0]      chan_thresh,
    output logic                  chan_stall,
    output logic [N_CNT-1:0]      irq
);
    import sca_pkg::*;

    reg_sel_e               sel;
    logic [IDXW-1:0]        ridx;
    logic [N_CNT*AMTW-1:0]  amt;
    logic [CNT_W-1:0]       cnt_a [N_CNT];
    logic [CNT_W-1:0]       thr_a [N_CNT];
    logic [N_CNT-1:0]       en_v, st_v, reached_v;
    logic [CNT_W-1:0]       chan_diff;

    assign sel  = reg_sel_e'(reg_addr[ADDR_W-1 -: 2]);
    assign ridx = reg_addr[IDXW-1:0];

    sca_inc_decode #(.N_CNT(N_CNT), .N_ENG(N_ENG), .IDXW(IDXW), .AMTW(AMTW)) u_dec (
        .eng_vld (eng_inc_vld),
        .eng_idx (eng_inc_idx),
        .sw_vld  (reg_wr && (sel == SEL_COUNT)),
        .sw_idx  (ridx),
        .amt     (amt)
    );

    for (genvar i = 0; i < N_CNT; i++) begin : g_slot
        logic hit;
        assign hit = reg_wr && (ridx == IDXW'(i));
        sca_slot #(.CW(CNT_W), .AMTW(AMTW)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .amt       (amt[i*AMTW +: AMTW]),
            .thr_we    (hit && (sel == SEL_THRESH)),
            .thr_wdata (reg_wdata),
            .en_we     (hit && (sel == SEL_ENABLE)),
            .en_wdata  (reg_wdata[0]),
            .st_clr    (hit && (sel == SEL_STATUS) && reg_wdata[0]),
            .cnt       (cnt_a[i]),
            .thr       (thr_a[i]),
            .en        (en_v[i]),
            .st        (st_v[i]),
            .reached   (reached_v[i])
        );
    end

    // Read mux over the four register kinds.
    always_comb begin
        unique case (sel)
            SEL_COUNT:  reg_rdata = cnt_a[ridx];
            SEL_THRESH: reg_rdata = thr_a[ridx];
            SEL_ENABLE: reg_rdata = {{(CNT_W-1){1'b0}}, en_v[ridx]};
            default:    reg_rdata = {{(CNT_W-1){1'b0}}, st_v[ridx]};
        endcase
    end

    // Channel stall: hold while the selected counter is behind the channel's target.
    always_comb begin
        chan_diff  = cnt_a[chan_idx] - chan_thresh;
        chan_stall = chan_wait & chan_diff[CNT_W-1];
    end

    // Interrupt lines gate status with enable.
    assign irq = st_v & en_v;

    AST_FLAG_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_ENABLE || sel == SEL_STATUS) |-> reg_rdata[CNT_W-1:1] == '0); // R9
    AST_STALL_NEEDS_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_wait |-> !chan_stall);                                              // R5
    AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq[0]) |-> st_v[0] && en_v[0]);                                    // R8
endmodule

// File: tb/sync_counter_array_tb_top.sv
`timescale 1ns/1ps
module sync_counter_array_tb_top;
    localparam int NC = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  eng_vld = '0;
    logic [5:0]  eng_idx = '0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        chan_wait = 1'b0;
    logic [2:0]  chan_idx = '0;
    logic [31:0] chan_thresh = '0;
    logic [31:0] rdata32;
    logic [7:0]  rdata8;
    logic        stall32, stall8;
    logic [7:0]  irq32, irq8;

    int n_chk = 0;
    int n_fail = 0;

    logic [31:0] m_cnt [2][NC];
    logic [31:0] m_thr [2][NC];
    bit          m_en  [2][NC];
    bit          m_st  [2][NC];
    bit          m_rq  [2][NC];

    always #2.5 clk = ~clk;

    sync_counter_array #(.N_CNT(8), .N_ENG(2), .CNT_W(32)) dut_i (
        .clk(clk), .rst_n(rst_n), .eng_inc_vld(eng_vld), .eng_inc_idx(eng_idx),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rdata32),
        .chan_wait(chan_wait), .chan_idx(chan_idx), .chan_thresh(chan_thresh),
        .chan_stall(stall32), .irq(irq32));

    sync_counter_array #(.N_CNT(8), .N_ENG(2), .CNT_W(8)) dut_w (
        .clk(clk), .rst_n(rst_n), .eng_inc_vld(eng_vld), .eng_inc_idx(eng_idx),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata[7:0]), .reg_rdata(rdata8),
        .chan_wait(chan_wait), .chan_idx(chan_idx), .chan_thresh(chan_thresh[7:0]),
        .chan_stall(stall8), .irq(irq8));

    function automatic logic [31:0] wmask(int k);
        return (k == 0) ? 32'hFFFF_FFFF : 32'h0000_00FF;
    endfunction

    // R4: reached when the top bit of the modular difference is clear.
    function automatic bit reach(int k, logic [31:0] c, logic [31:0] t);
        logic [31:0] d;
        d = (c - t) & wmask(k);
        return (k == 0) ? !d[31] : !d[7];
    endfunction

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(logic [1:0] v, logic [2:0] i0, logic [2:0] i1, logic wr,
                        logic [1:0] sel, logic [2:0] idx, logic [31:0] wd,
                        logic cw, logic [2:0] ci, logic [31:0] ct);
        @(negedge clk);
        eng_vld = v; eng_idx = {i1, i0};
        reg_wr = wr; reg_addr = {sel, idx}; reg_wdata = wd;
        chan_wait = cw; chan_idx = ci; chan_thresh = ct;
        #1;
        for (int k = 0; k < 2; k++) begin
            logic [31:0] exp_rd, act_rd;
            logic [7:0]  exp_irq, act_irq;
            bit          exp_st, act_st;
            case (sel)
                2'd0: exp_rd = m_cnt[k][idx];
                2'd1: exp_rd = m_thr[k][idx];
                2'd2: exp_rd = {31'b0, m_en[k][idx]};
                default: exp_rd = {31'b0, m_st[k][idx]};
            endcase
            act_rd  = (k == 0) ? rdata32 : {24'b0, rdata8};
            act_irq = (k == 0) ? irq32 : irq8;
            act_st  = (k == 0) ? stall32 : stall8;
            for (int n = 0; n < NC; n++) exp_irq[n] = m_st[k][n] & m_en[k][n];
            exp_st = cw && !reach(k, m_cnt[k][ci], ct & wmask(k));
            case (sel)
                2'd0: chk(act_rd == exp_rd, "R2 R3 counter read", act_rd, exp_rd);
                2'd3: chk(act_rd == exp_rd, "R6 R7 status read", act_rd, exp_rd);
                default: chk(act_rd == exp_rd, "R9 register read", act_rd, exp_rd);
            endcase
            chk(act_irq == exp_irq, "R8 irq", {24'b0, act_irq}, {24'b0, exp_irq});
            chk(act_st == exp_st, "R4 R5 stall", {31'b0, act_st}, {31'b0, exp_st});
        end
        // Advance the model to the state after the coming edge.
        for (int k = 0; k < 2; k++) begin
            for (int n = 0; n < NC; n++) begin
                bit          r, clr, here;
                logic [31:0] hits;
                here = wr && (idx == 3'(n));
                r    = reach(k, m_cnt[k][n], m_thr[k][n]);
                hits = 32'(v[0] && i0 == 3'(n)) + 32'(v[1] && i1 == 3'(n))
                     + 32'(here && sel == 2'd0);
                clr  = here && sel == 2'd3 && wd[0];
                m_st[k][n]  = (m_st[k][n] && !clr) || (r && !m_rq[k][n]);
                m_rq[k][n]  = r;
                m_cnt[k][n] = (m_cnt[k][n] + hits) & wmask(k);
                if (here && sel == 2'd1) m_thr[k][n] = wd & wmask(k);
                if (here && sel == 2'd2) m_en[k][n]  = wd[0];
            end
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5ca1_0042));
        for (int k = 0; k < 2; k++)
            for (int n = 0; n < NC; n++) begin
                m_cnt[k][n] = '0; m_thr[k][n] = '0;
                m_en[k][n] = 0; m_st[k][n] = 0; m_rq[k][n] = 1;
            end
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        // R1: reset state visible at the ports.
        chk(irq32 == 8'h0 && irq8 == 8'h0, "R1 irq after reset", {24'b0, irq32}, 32'h0);
        chk(rdata32 == 32'h0, "R1 counter 0 after reset", rdata32, 32'h0);
        for (int a = 0; a < 32; a++)
            step(2'b00, 0, 0, 1'b0, 2'(a >> 3), 3'(a), 32'h0, 1'b0, 0, 32'h0);

        // R4: threshold all-ones, counter 0 -> already reached, no stall.
        step(2'b00, 0, 0, 1'b1, 2'd1, 3, 32'hFFFF_FFFF, 1'b1, 3, 32'hFFFF_FFFF);
        step(2'b00, 0, 0, 1'b0, 2'd1, 3, 32'h0, 1'b1, 3, 32'hFFFF_FFFF);
        step(2'b00, 0, 0, 1'b0, 2'd0, 3, 32'h0, 1'b1, 3, 32'h8000_0000);
        step(2'b00, 0, 0, 1'b0, 2'd0, 3, 32'h0, 1'b1, 3, 32'h1);

        // R5 R6 R8: counter 2 climbs to threshold 5 with interrupt enabled.
        step(2'b00, 0, 0, 1'b1, 2'd1, 2, 32'd5, 1'b1, 2, 32'd5);
        step(2'b00, 0, 0, 1'b1, 2'd2, 2, 32'd1, 1'b1, 2, 32'd5);
        for (int s = 0; s < 6; s++)
            step(2'b01, 2, 0, 1'b0, 2'd3, 2, 32'h0, 1'b1, 2, 32'd5);
        // R7: write 0 keeps status, write 1 clears it.
        step(2'b00, 0, 0, 1'b1, 2'd3, 2, 32'h0, 1'b0, 0, 32'h0);
        step(2'b00, 0, 0, 1'b1, 2'd3, 2, 32'h1, 1'b0, 0, 32'h0);
        step(2'b00, 0, 0, 1'b0, 2'd3, 2, 32'h0, 1'b0, 0, 32'h0);
        // R3: two engine ports plus a software increment on one index.
        step(2'b11, 4, 4, 1'b1, 2'd0, 4, 32'hDEAD_BEEF, 1'b0, 0, 32'h0);
        step(2'b11, 5, 6, 1'b0, 2'd0, 4, 32'h0, 1'b0, 0, 32'h0);
        step(2'b00, 0, 0, 1'b0, 2'd0, 5, 32'h0, 1'b0, 0, 32'h0);

        // Random phase: R2 wrap is reached many times by the 8-bit instance.
        for (int it = 0; it < 4000; it++) begin
            logic [2:0]  idx, ci;
            logic [1:0]  sel;
            logic [31:0] wd, ct;
            idx = 3'($urandom_range(0, 7));
            ci  = 3'($urandom_range(0, 7));
            sel = 2'($urandom_range(0, 3));
            if (sel == 2'd1 && $urandom_range(0, 3) != 0)
                wd = m_cnt[0][idx] + 32'($urandom_range(0, 40)) - 32'd20;
            else
                wd = $urandom;
            if ($urandom_range(0, 3) == 0) ct = $urandom;
            else ct = m_cnt[0][ci] + 32'($urandom_range(0, 6)) - 32'd2;
            step(2'($urandom_range(0, 3)), 3'($urandom_range(0, 7)), 3'($urandom_range(0, 7)),
                 1'($urandom_range(0, 2) == 0), sel, idx, wd,
                 1'($urandom_range(0, 1)), ci, ct);
        end
        finish_run();
    end
endmodule